// File: doc/BRIEF.md
# Bidirectional GPIO Port with Read-Modify-Write Bit Commands

This block is an 8-bit general-purpose I/O port attached to a small microcontroller bus. Each pin has a direction bit, an output latch bit and an open-drain select bit. Pin levels reach the register logic through a two-flop synchronizer. The pad side gets an output value and an output enable per pin, and these work in either push-pull or N-channel open-drain style.

Software reads and writes the data, direction and open-drain select registers a byte at a time. It can also issue a single-cycle bit command that sets or clears one bit of the port. The bit command works on the whole byte. It reads the port the same way a data-register read does, changes the addressed bit, and writes all eight bits back into the latch. So a pin configured as input has its latch overwritten with the synchronized pin level, even when that bit was not addressed. The latch keeps that value and drives it later if the pin becomes an output.

Top module: `gpio_rmw_port`

## Requirements
- R1: After reset the direction, open-drain select and data latch registers all read 0, and every pad output enable is 0.
- R2: A read with `bus_addr` = 0 (data) returns, for each bit, the latch bit when the direction bit is 1 (output) and the synchronized pin level when it is 0 (input).
- R3: A write to address 0 loads all 8 latch bits with the written byte, whatever the direction bits are. The new value is visible from the next clock edge.
- R4: A bit command with `bit_set` = 1 makes latch bit `bit_idx` equal to 1 after the clock edge, and with `bit_set` = 0 makes it 0.
- R5: During a bit command, every non-addressed input bit (direction 0) has its latch loaded with the synchronized pin level, even when that level differs from the old latch value.
- R6: During a bit command, every non-addressed output bit keeps its latch value.
- R7: A write to the direction register (address 1) leaves every latch bit unchanged.
- R8: For a bit whose open-drain select is 0, the pad output enable equals the direction bit and the pad output equals the latch bit.
- R9: For a bit whose open-drain select is 1 and whose direction is output, the pad is enabled and drives 0 when the latch is 0. When the latch is 1 the output enable is 0 (high impedance). The pad output value is never 1 with the enable on.
- R10: A change on `pin_in` shows up in data reads after exactly two rising clock edges, and not after one.
- R11: When `bus_wr` and `bit_cmd` are asserted in the same cycle, the bus write takes effect and the bit command is dropped.
- R12: The direction register (address 1) and the open-drain select register (address 2) read back the last byte written to them. Address 3 reads 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 data, 1 direction, 2 open-drain select, 3 unused |
| bus_wr | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Byte write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| bit_cmd | input | 1 | Single-cycle bit set/clear command |
| bit_idx | input | 3 | Bit addressed by the command |
| bit_set | input | 1 | 1 sets the addressed bit, 0 clears it |
| pin_in | input | 8 | Asynchronous pin levels from the pads |
| pad_out | output | 8 | Output value to the pads |
| pad_oe | output | 8 | Output enable to the pads |

## Verification
The hardest case to reach is the one where a bit command silently changes a bit it did not address. Three conditions must hold together. The bit must be an input. Its pin level must have passed through both synchronizer stages. That level must differ from an earlier latch value that software cannot see while the bit stays an input. The stimulus gets there in steps. It writes the latch while every bit is still an input, moves some of the bits to output, and drives pins that disagree with the latch for at least two edges. Only then does it issue the bit command. It then switches all bits to output, so that the rewritten latch appears on the data read and on the pads.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int PORT_W = 8;
  localparam int IDX_W  = $clog2(PORT_W);
  localparam int ADDR_W = 2;

  typedef logic [PORT_W-1:0] port_t;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DATA  = 2'd0,
    SEL_DIR   = 2'd1,
    SEL_ODSEL = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // Per-bit view of the port: latch for outputs, pin for inputs.
  function automatic port_t port_view(port_t dir, port_t lat, port_t pin);
    return (dir & lat) | (~dir & pin);
  endfunction

  // One-hot mask of the addressed bit.
  function automatic port_t bit_mask(logic [IDX_W-1:0] idx);
    return port_t'(1) << idx;
  endfunction

  // Whole-byte read-modify-write: read the view, patch one bit.
  function automatic port_t rmw_byte(port_t view, logic [IDX_W-1:0] idx, logic set);
    port_t m;
    m = bit_mask(idx);
    return set ? (view | m) : (view & ~m);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_async;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  port_t             bus_wdata,
  output port_t             bus_rdata,
  input  logic              bit_cmd,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              bit_set,
  input  port_t             pin_sync,
  output port_t             dir_q,
  output port_t             lat_q,
  output port_t             od_q
);
  // Named internal events for the assertions.
  logic  data_wr_ev, dir_wr_ev, od_wr_ev, bit_ev, bit_drop_ev;
  port_t view_w, rmw_w, idx_mask_w;

  assign data_wr_ev  = bus_wr && (bus_addr == SEL_DATA);
  assign dir_wr_ev   = bus_wr && (bus_addr == SEL_DIR);
  assign od_wr_ev    = bus_wr && (bus_addr == SEL_ODSEL);
  assign bit_ev      = bit_cmd && !bus_wr;
  assign bit_drop_ev = bit_cmd && bus_wr;

  assign view_w     = port_view(dir_q, lat_q, pin_sync);
  assign idx_mask_w = bit_mask(bit_idx);
  assign rmw_w      = rmw_byte(view_w, bit_idx, bit_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lat_q <= '0;
      od_q  <= '0;
    end else begin
      if (dir_wr_ev)  dir_q <= bus_wdata;
      if (od_wr_ev)   od_q  <= bus_wdata;
      if (data_wr_ev) lat_q <= bus_wdata;
      else if (bit_ev) lat_q <= rmw_w;
    end
  end

  always_comb begin
    unique case (reg_sel_e'(bus_addr))
      SEL_DATA:  bus_rdata = view_w;
      SEL_DIR:   bus_rdata = dir_q;
      SEL_ODSEL: bus_rdata = od_q;
      default:   bus_rdata = '0;
    endcase
  end

  assert_wr_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_ev |=> lat_q == $past(bus_wdata));

  assert_bit_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ev |=> lat_q[$past(bit_idx)] == $past(bit_set));

  assert_in_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ev |=> ((lat_q ^ $past(pin_sync)) & ~$past(dir_q) & ~$past(idx_mask_w)) == '0);

  assert_out_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ev |=> ((lat_q ^ $past(lat_q)) & $past(dir_q) & ~$past(idx_mask_w)) == '0);

  assert_dir_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr_ev |=> $stable(lat_q));

  assert_drop_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_drop_ev && !data_wr_ev) |=> $stable(lat_q));
endmodule

// File: rtl/gpio_pad.sv
module gpio_pad
  import gpio_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  port_t dir_q,
  input  port_t lat_q,
  input  port_t od_q,
  output port_t pad_out,
  output port_t pad_oe
);
  for (genvar b = 0; b < PORT_W; b++) begin : g_bit
    always_comb begin
      if (od_q[b]) begin
        // N-channel: only pull low; a latched 1 floats.
        pad_out[b] = 1'b0;
        pad_oe[b]  = dir_q[b] & ~lat_q[b];
      end else begin
        pad_out[b] = lat_q[b];
        pad_oe[b]  = dir_q[b];
      end
    end
  end

  assert_od_no_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_out & od_q) == '0);

  assert_od_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & od_q & lat_q) == '0);

  assert_pp_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe ^ dir_q) & ~od_q) == '0);

  assert_input_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~dir_q) == '0);
endmodule

// File: rtl/gpio_rmw_port.sv
module gpio_rmw_port
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic              bit_cmd,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              bit_set,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe
);
  localparam int SYNC_STAGES = 2;

  port_t pin_sync, dir_q, lat_q, od_q;

  gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(pin_sync)
  );

  gpio_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bit_cmd(bit_cmd),
    .bit_idx(bit_idx), .bit_set(bit_set), .pin_sync(pin_sync),
    .dir_q(dir_q), .lat_q(lat_q), .od_q(od_q)
  );

  gpio_pad u_pad (
    .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .lat_q(lat_q), .od_q(od_q),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );
endmodule

// File: tb/test_gpio_rmw_port.sv
module test_gpio_rmw_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       bit_cmd = 1'b0;
  logic [2:0] bit_idx = 3'd0;
  logic       bit_set = 1'b0;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] pad_out, pad_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_rmw_port i_gpio_rmw_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bit_cmd(bit_cmd),
    .bit_idx(bit_idx), .bit_set(bit_set), .pin_in(pin_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // Bench-side model of the port state.
  logic [7:0] m_dir = 8'h00, m_lat = 8'h00, m_od = 8'h00, m_pin = 8'h00;

  function automatic logic [7:0] exp_read(logic [1:0] a);
    case (a)
      2'd0: return (m_pin & ~m_dir) | (m_lat & m_dir);
      2'd1: return m_dir;
      2'd2: return m_od;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_oe();
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = m_dir[b] && !(m_od[b] && m_lat[b]);
    return r;
  endfunction

  function automatic logic [7:0] exp_out();
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = m_od[b] ? 1'b0 : m_lat[b];
    return r;
  endfunction

  // Scoreboard items: kind 0 read data, 1 pad_oe, 2 pad_out.
  typedef struct {
    string      req;
    logic [1:0] addr;
    int         kind;
    logic [7:0] exp;
  } item_t;
  item_t sb_q[$];

  task automatic push(string req, logic [1:0] a, int kind, logic [7:0] e);
    item_t it;
    it.req = req; it.addr = a; it.kind = kind; it.exp = e;
    sb_q.push_back(it);
  endtask

  task automatic push_read(string req, logic [1:0] a);
    push(req, a, 0, exp_read(a));
  endtask

  task automatic push_pads(string req);
    push(req, 2'd0, 1, exp_oe());
    push(req, 2'd0, 2, exp_out());
  endtask

  // Monitor: pop each expected item and compare against the live outputs.
  task automatic monitor_drain();
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] got;
      it = sb_q.pop_front();
      bus_addr = it.addr;
      #0.5;
      case (it.kind)
        0: got = bus_rdata;
        1: got = pad_oe;
        default: got = pad_out;
      endcase
      n_cmp++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d addr=%0d actual=%02h expected=%02h",
                 it.req, it.kind, it.addr, got, it.exp);
      end
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      2'd0: m_lat = d;
      2'd1: m_dir = d;
      2'd2: m_od  = d;
      default: ;
    endcase
  endtask

  task automatic bit_op(logic [2:0] i, logic s);
    logic [7:0] v;
    v = exp_read(2'd0);
    v[i] = s;
    bit_idx = i; bit_set = s; bit_cmd = 1'b1;
    @(posedge clk); @(negedge clk);
    bit_cmd = 1'b0;
    m_lat = v;
  endtask

  task automatic drive_pins(logic [7:0] p);
    pin_in = p;
    @(posedge clk); @(posedge clk); @(negedge clk);
    m_pin = p;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    push_read("R1", 2'd1); push_read("R1", 2'd2); push_read("R1", 2'd0);
    push("R1", 2'd0, 1, 8'h00);
    monitor_drain();

    // R2: all inputs, data read shows pins
    drive_pins(8'hA5);
    push_read("R2", 2'd0); monitor_drain();

    // R10: one edge is not enough, two are
    pin_in = 8'h3C;
    @(posedge clk); @(negedge clk);
    push("R10", 2'd0, 0, 8'hA5); monitor_drain();
    @(posedge clk); @(negedge clk);
    m_pin = 8'h3C;
    push("R10", 2'd0, 0, 8'h3C); monitor_drain();

    // R3: byte write loads latch while all bits are inputs
    bus_write(2'd0, 8'hF0);
    push("R3", 2'd0, 0, 8'h3C); monitor_drain();
    bus_write(2'd1, 8'hFF);
    push("R3", 2'd0, 0, 8'hF0);
    push_pads("R8"); monitor_drain();

    // R2 / R7: mixed directions; latch kept across direction changes
    bus_write(2'd1, 8'h0F);
    push("R2", 2'd0, 0, 8'h30); monitor_drain();
    push_pads("R8"); monitor_drain();

    // R5 / R6 / R4: bit set on bit 0, upper input bits reload from pins
    bit_op(3'd0, 1'b1);
    bus_write(2'd1, 8'hFF);
    push("R5", 2'd0, 0, 8'h31); monitor_drain();
    push_read("R6", 2'd0); monitor_drain();

    // R7: direction write alone leaves latch intact
    bus_write(2'd1, 8'h00);
    bus_write(2'd1, 8'hFF);
    push_read("R7", 2'd0); monitor_drain();

    // R4: clear bit 5 with all outputs
    bit_op(3'd5, 1'b0);
    push("R4", 2'd0, 0, 8'h11); monitor_drain();
    bit_op(3'd7, 1'b1);
    push("R4", 2'd0, 0, 8'h91); monitor_drain();

    // R9: open-drain on all bits
    bus_write(2'd2, 8'hFF);
    push("R9", 2'd0, 1, 8'h6E);
    push("R9", 2'd0, 2, 8'h00);
    push("R12", 2'd2, 0, 8'hFF); monitor_drain();
    // mixed open-drain select
    bus_write(2'd2, 8'h0F);
    push_pads("R9"); push_read("R12", 2'd2); monitor_drain();

    // R11: write and bit command together: write wins
    bus_addr = 2'd0; bus_wdata = 8'h55; bus_wr = 1'b1;
    bit_idx = 3'd1; bit_set = 1'b1; bit_cmd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bit_cmd = 1'b0; m_lat = 8'h55;
    push("R11", 2'd0, 0, 8'h55); monitor_drain();
    // dropped command during a direction write leaves latch as is
    bus_addr = 2'd1; bus_wdata = 8'hFF; bus_wr = 1'b1;
    bit_idx = 3'd0; bit_set = 1'b0; bit_cmd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bit_cmd = 1'b0;
    push("R11", 2'd0, 0, 8'h55); monitor_drain();

    // R12: unused address reads 0 and writes do nothing
    bus_write(2'd3, 8'hFF);
    push("R12", 2'd3, 0, 8'h00);
    push_read("R12", 2'd0); push_read("R12", 2'd1); push_read("R12", 2'd2);
    monitor_drain();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule